// File: doc/BRIEF.md
# Transmit Buffer Abort Controller

This block keeps the status and control of a small set of transmit message buffers in a CAN controller. Each buffer has a transmitter-empty flag, an abort-request bit, an abort-acknowledge flag and an interrupt enable. The host reaches all of them through a byte-wide register bus with combinational reads. A protocol engine outside the block reports, per buffer, when a frame starts and whether it ends in success, lost arbitration or an error. Bit-level framing, arbitration and message storage are handled elsewhere.

The host schedules a buffer by writing 1 to that buffer's empty flag, which clears the flag. While a buffer is scheduled, the host may ask to abort it. The block grants the abort if the frame has not yet started, or when a started frame fails. A granted abort returns the buffer to empty and raises its acknowledge flag. The abort request cannot be withdrawn by the host. It clears itself in the cycle the buffer's empty flag sets. A soft-reset input holds the control register at zero.

Each buffer runs a small state machine. It has three states. `SLOT_EMPTY` means the buffer is available. `SLOT_QUEUED` means it is scheduled but not on the bus. `SLOT_ACTIVE` means its frame is being sent. The transitions are as follows:
- schedule: EMPTY to QUEUED.
- launch: QUEUED to ACTIVE, on a start report.
- early grant: QUEUED to EMPTY, when an abort request is pending.
- complete: ACTIVE to EMPTY, on success.
- late grant: ACTIVE to EMPTY, on failure with an abort pending.
- retry: ACTIVE to QUEUED, on failure with no abort pending.

Top module: `txab_ctrl`

## Requirements
- R1: After reset, the flag register (address 0) reads 0x07. Empty flags are in bits 2..0 and are all 1. Acknowledge flags are in bits 6..4 and are all 0. The control register (address 1) reads 0x00.
- R2: The control register holds abort requests for buffers 2..0 in bits 6..4 and interrupt enables for buffers 2..0 in bits 2..0. Bits 7 and 3 read as 0. Any other address reads 0x00.
- R3: A write of 1 to flag-register bit i schedules buffer i. This clears its empty flag and its acknowledge flag. A 0 in that bit has no effect.
- R4: A control-register write of 1 in bit 4+i sets abort request i only while buffer i's empty flag is 0. Writing 0 to a set request has no effect.
- R5: A pending abort on a buffer whose frame has not started is granted at the next clock edge. At that edge the empty flag and the acknowledge flag become 1 and the request clears.
- R6: A pending abort on a started frame is granted at the edge where lost arbitration or an error is reported. The empty and acknowledge flags set and the request clears.
- R7: A pending abort on a started frame that then succeeds is not granted. The empty flag sets, the request clears and the acknowledge flag stays 0.
- R8: A failed frame with no pending abort leaves its buffer scheduled, so the empty flag stays 0.
- R9: Interrupt line i (txe_irq_o[i]) is the empty flag ANDed with enable i. irq_o is the OR of all the lines.
- R10: While soft_rst_i is 1, the control register reads 0x00 and ignores writes. The buffer flags are not affected.
- R11: A flag-register write with both bit i and bit 4+i set is illegal. bad_wr_o is 1 for the cycle after the write. Abort request i stays 0, and buffer i is still scheduled.
- R12: A legal flag-register write of 1 in bit 4+i to a scheduled buffer sets abort request i, just as a control-register write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Holds the control register at its reset value |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| tx_start_i | input | NBUF | Engine began sending buffer i |
| tx_ok_i | input | NBUF | Frame of buffer i sent successfully |
| tx_lost_i | input | NBUF | Frame of buffer i lost arbitration |
| tx_err_i | input | NBUF | Frame of buffer i ended in error |
| txe_irq_o | output | NBUF | Per-buffer transmitter-empty interrupt |
| irq_o | output | 1 | OR of all per-buffer interrupts |
| bad_wr_o | output | 1 | Pulse one cycle after an illegal flag write |

## Verification
The bench builds the block with its default parameters: three buffers (NBUF=3) and a two-bit address (AW=2). With these values all three register bit lanes are in use, and the unused address 2 can be read. The stimulus drives every state-machine transition on a different buffer. It then brings the acknowledge flags of different buffers to overlap, so a wrong bit lane shows up in the read value. The clear-versus-set collisions are also exercised: an illegal combined write, a zero written over a pending request, and writes made during soft reset.

// File: rtl/txab_pkg.sv
package txab_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_QUEUED = 2'd1,
        SLOT_ACTIVE = 2'd2
    } slot_state_e;

    localparam int FLAG_ADDR = 0;
    localparam int CTRL_ADDR = 1;
    localparam int ABT_LSB   = 4;
endpackage

// File: rtl/txab_slot.sv
module txab_slot
    import txab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic sched_i,
    input  logic abort_set_i,
    input  logic start_i,
    input  logic ok_i,
    input  logic fail_i,
    output logic txe_o,
    output logic areq_o,
    output logic ack_o
);
    slot_state_e state_q, state_d;
    logic        grant;
    logic        areq_q, ack_q;
    logic        set_empty;

    // next-state logic
    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (sched_i) state_d = SLOT_QUEUED;
            end
            SLOT_QUEUED: begin
                if (areq_q) begin
                    state_d = SLOT_EMPTY;
                    grant   = 1'b1;
                end else if (start_i) begin
                    state_d = SLOT_ACTIVE;
                end
            end
            SLOT_ACTIVE: begin
                if (ok_i) begin
                    state_d = SLOT_EMPTY;
                end else if (fail_i) begin
                    if (areq_q) begin
                        state_d = SLOT_EMPTY;
                        grant   = 1'b1;
                    end else begin
                        state_d = SLOT_QUEUED;
                    end
                end
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    assign set_empty = (state_q != SLOT_EMPTY) && (state_d == SLOT_EMPTY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            areq_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            if (soft_rst_i || set_empty)
                areq_q <= 1'b0;
            else if (abort_set_i && (state_q != SLOT_EMPTY))
                areq_q <= 1'b1;

            if (grant)
                ack_q <= 1'b1;
            else if (sched_i && (state_q == SLOT_EMPTY))
                ack_q <= 1'b0;
        end
    end

    assign txe_o  = (state_q == SLOT_EMPTY);
    assign areq_o = areq_q;
    assign ack_o  = ack_q;
endmodule

// File: rtl/txab_regs.sv
module txab_regs
    import txab_pkg::*;
#(
    parameter int NBUF = 3,
    parameter int AW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst_i,
    input  logic            wr_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [7:0]      wdata_i,
    input  logic [NBUF-1:0] txe_i,
    input  logic [NBUF-1:0] areq_i,
    input  logic [NBUF-1:0] ack_i,
    output logic [NBUF-1:0] sched_o,
    output logic [NBUF-1:0] abort_set_o,
    output logic [NBUF-1:0] ie_o,
    output logic            bad_wr_o,
    output logic [7:0]      rdata_o
);
    logic            flag_wr, ctrl_wr;
    logic [NBUF-1:0] clash;
    logic [NBUF-1:0] ie_q;
    logic            bad_q;
    logic            unused_wbits;

    assign flag_wr = wr_i && (addr_i == AW'(FLAG_ADDR));
    assign ctrl_wr = wr_i && (addr_i == AW'(CTRL_ADDR));
    assign unused_wbits = ^wdata_i;

    for (genvar i = 0; i < NBUF; i++) begin : g_lane
        assign sched_o[i]     = flag_wr && wdata_i[i];
        assign clash[i]       = flag_wr && wdata_i[i] && wdata_i[ABT_LSB+i];
        assign abort_set_o[i] = (flag_wr || ctrl_wr) && wdata_i[ABT_LSB+i]
                                && !clash[i] && !soft_rst_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q  <= '0;
            bad_q <= 1'b0;
        end else begin
            if (soft_rst_i)   ie_q <= '0;
            else if (ctrl_wr) ie_q <= wdata_i[NBUF-1:0];
            bad_q <= |clash;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(FLAG_ADDR)) begin
            for (int i = 0; i < NBUF; i++) begin
                rdata_o[i]         = txe_i[i];
                rdata_o[ABT_LSB+i] = ack_i[i];
            end
        end else if (addr_i == AW'(CTRL_ADDR)) begin
            for (int i = 0; i < NBUF; i++) begin
                rdata_o[i]         = ie_q[i];
                rdata_o[ABT_LSB+i] = areq_i[i];
            end
        end
    end

    assign ie_o     = ie_q;
    assign bad_wr_o = bad_q;
endmodule

// File: rtl/txab_ctrl.sv
module txab_ctrl
    import txab_pkg::*;
#(
    parameter int NBUF = 3,
    parameter int AW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst_i,
    input  logic            bus_wr_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [7:0]      bus_wdata_i,
    output logic [7:0]      bus_rdata_o,
    input  logic [NBUF-1:0] tx_start_i,
    input  logic [NBUF-1:0] tx_ok_i,
    input  logic [NBUF-1:0] tx_lost_i,
    input  logic [NBUF-1:0] tx_err_i,
    output logic [NBUF-1:0] txe_irq_o,
    output logic            irq_o,
    output logic            bad_wr_o
);
    logic [NBUF-1:0] txe, areq, ack, ie;
    logic [NBUF-1:0] sched, abort_set;

    txab_regs #(.NBUF(NBUF), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_i  (soft_rst_i),
        .wr_i        (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .txe_i       (txe),
        .areq_i      (areq),
        .ack_i       (ack),
        .sched_o     (sched),
        .abort_set_o (abort_set),
        .ie_o        (ie),
        .bad_wr_o    (bad_wr_o),
        .rdata_o     (bus_rdata_o)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        txab_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .soft_rst_i  (soft_rst_i),
            .sched_i     (sched[i]),
            .abort_set_i (abort_set[i]),
            .start_i     (tx_start_i[i]),
            .ok_i        (tx_ok_i[i]),
            .fail_i      (tx_lost_i[i] | tx_err_i[i]),
            .txe_o       (txe[i]),
            .areq_o      (areq[i]),
            .ack_o       (ack[i])
        );
    end

    assign txe_irq_o = txe & ie;
    assign irq_o     = |txe_irq_o;
endmodule

// File: rtl/txab_ctrl_chk.sv
module txab_ctrl_chk #(
    parameter int NBUF = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            soft_rst_i,
    input logic [NBUF-1:0] txe,
    input logic [NBUF-1:0] areq,
    input logic [NBUF-1:0] ack,
    input logic [NBUF-1:0] ie,
    input logic [7:0]      rdata
);
    // R4
    areq_only_scheduled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (areq & txe) == '0);

    // R5
    ack_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack & ~txe) == '0);

    // R6
    ack_rise_with_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack & ~$past(ack)) & ~(txe & ~$past(txe))) == '0);

    // R10
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (areq == '0 && ie == '0));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[7] == 1'b0 && rdata[3] == 1'b0));
endmodule

bind txab_ctrl txab_ctrl_chk #(.NBUF(NBUF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .txe        (txe),
    .areq       (areq),
    .ack        (ack),
    .ie         (ie),
    .rdata      (bus_rdata_o)
);

// File: tb/txab_ctrl_tb.sv
module txab_ctrl_tb;
    localparam int NBUF = 3;
    localparam int AW   = 2;
    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_BAD = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            soft_rst_i = 1'b0;
    logic            bus_wr_i = 1'b0;
    logic [AW-1:0]   bus_addr_i = '0;
    logic [7:0]      bus_wdata_i = '0;
    logic [7:0]      bus_rdata_o;
    logic [NBUF-1:0] tx_start_i = '0, tx_ok_i = '0, tx_lost_i = '0, tx_err_i = '0;
    logic [NBUF-1:0] txe_irq_o;
    logic            irq_o, bad_wr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int       kind;
        logic [7:0] exp;
        string    req;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    txab_ctrl #(.NBUF(NBUF), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .tx_start_i(tx_start_i), .tx_ok_i(tx_ok_i),
        .tx_lost_i(tx_lost_i), .tx_err_i(tx_err_i), .txe_irq_o(txe_irq_o),
        .irq_o(irq_o), .bad_wr_o(bad_wr_o)
    );

    // monitor: pops expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata_o;
                    K_IRQ:   act = {4'b0, irq_o, txe_irq_o};
                    default: act = {7'b0, bad_wr_o};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    task automatic rd(input int addr, input logic [7:0] exp, input string req);
        bus_addr_i = AW'(addr);
        push(K_RD, exp, req);
    endtask

    task automatic wr(input int addr, input logic [7:0] data);
        bus_wr_i    = 1'b1;
        bus_addr_i  = AW'(addr);
        bus_wdata_i = data;
        tick();
        bus_wr_i = 1'b0;
    endtask

    task automatic pulse(input int sig, input int buf_i);
        case (sig)
            0: tx_start_i[buf_i] = 1'b1;
            1: tx_ok_i[buf_i]    = 1'b1;
            2: tx_lost_i[buf_i]  = 1'b1;
            default: tx_err_i[buf_i] = 1'b1;
        endcase
        tick();
        tx_start_i = '0; tx_ok_i = '0; tx_lost_i = '0; tx_err_i = '0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset values, R9 no interrupt with enables off
        rd(0, 8'h07, "R1"); tick();
        rd(1, 8'h00, "R1"); push(K_IRQ, 8'h00, "R9"); push(K_BAD, 8'h00, "R11");
        tick();
        // abort on empty buffers is ignored
        wr(1, 8'h77);
        rd(1, 8'h07, "R4"); push(K_IRQ, 8'h0F, "R9"); tick();
        // schedule buffer 0
        wr(0, 8'h01);
        rd(0, 8'h06, "R3"); push(K_IRQ, 8'h0E, "R9"); tick();
        // abort before start
        wr(1, 8'h17);
        rd(1, 8'h17, "R2"); tick();
        rd(0, 8'h17, "R5"); tick();
        rd(1, 8'h07, "R5"); push(K_IRQ, 8'h0F, "R9"); tick();
        // reschedule clears acknowledge
        wr(0, 8'h01);
        rd(0, 8'h06, "R3"); tick();
        // abort pending during a frame that succeeds
        pulse(0, 0);
        wr(1, 8'h17);
        wr(1, 8'h07);
        rd(1, 8'h17, "R4"); tick();
        rd(0, 8'h06, "R7");
        pulse(1, 0);
        rd(0, 8'h07, "R7"); tick();
        rd(1, 8'h07, "R7"); tick();
        // abort pending, lost arbitration on buffer 1
        wr(0, 8'h02);
        rd(0, 8'h05, "R3");
        pulse(0, 1);
        wr(1, 8'h27);
        pulse(2, 1);
        rd(0, 8'h27, "R6"); tick();
        rd(1, 8'h07, "R6"); tick();
        // buffer 2 error without abort retries
        wr(0, 8'h04);
        pulse(0, 2);
        pulse(3, 2);
        rd(0, 8'h23, "R8"); tick();
        wr(1, 8'h47);
        rd(1, 8'h47, "R4"); tick();
        rd(0, 8'h67, "R5"); tick();
        // illegal combined write on buffer 0
        wr(0, 8'h11);
        push(K_BAD, 8'h01, "R11"); rd(1, 8'h07, "R11"); tick();
        push(K_BAD, 8'h00, "R11"); rd(0, 8'h66, "R11"); tick();
        // abort through the flag register
        wr(0, 8'h10);
        rd(1, 8'h17, "R12"); tick();
        rd(0, 8'h77, "R12"); tick();
        // soft reset
        wr(0, 8'h01);
        rd(0, 8'h66, "R3"); push(K_IRQ, 8'h0E, "R9");
        soft_rst_i = 1'b1;
        tick();
        rd(1, 8'h00, "R10"); push(K_IRQ, 8'h00, "R10");
        wr(1, 8'h17);
        rd(1, 8'h00, "R10"); tick();
        rd(0, 8'h66, "R10");
        soft_rst_i = 1'b0;
        tick();
        rd(1, 8'h00, "R10"); tick();
        // reserved bits and unused address
        wr(1, 8'hFF);
        rd(1, 8'h17, "R2"); tick();
        rd(0, 8'h77, "R5"); push(K_IRQ, 8'h0F, "R9"); tick();
        rd(2, 8'h00, "R2"); tick();
        tick();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1-scope run actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule